// File: doc/BRIEF.md
# Coherent Interconnect Performance Monitor

This block counts selected coherent transaction events reported by the upstream interfaces of a cache-coherent interconnect. It does not decode bus traffic itself. Each upstream port supplies one pulse per transaction class and a flag that marks the event as secure. A bank of event counters picks up these pulses. Each counter has its own event-select register and enable bit, and it adds in one cycle the number of qualified ports that report its selected class.

Debug-enable inputs gate counting. The invasive debug enable must be high for anything to count. A secure event also needs the secure debug enable. A non-secure event also needs the non-invasive enable. A 32-bit counter wraps to zero and sets a sticky overflow flag, and that flag drives its own interrupt output until software clears it. Software reaches all of this through a single-cycle write port with a combinational read-back.

Top module: `cohi_perfmon`

## Requirements
- R1: After synchronous reset, every counter value, event select, enable bit and overflow flag is zero, and every interrupt output is low.
- R2: Event input bit `p*6+k` carries class k of port p. The select code that counts each class is: class 0 (ReadOnce) code 3; class 1 (ReadClean/ReadShared/ReadNotSharedDirty/ReadUnique) code 4; class 2 (MakeUnique/CleanUnique) code 5; class 3 (CleanInvalid/CleanShared/MakeInvalid) code 6; class 4 (DVM received) code 7; class 5 (read data supplied by snoop) code 9.
- R3: A select code other than 3, 4, 5, 6, 7 or 9 is stored and read back, but the counter never increments.
- R4: While the invasive debug enable is low, no counter increments.
- R5: An event flagged secure is counted only when both the invasive and the secure debug enables are high.
- R6: An event not flagged secure is counted only when both the invasive and the non-invasive enables are high.
- R7: In one cycle a counter adds the number of ports that report its selected class with a qualified pulse.
- R8: A counter whose enable bit (control register bit 0) is clear does not increment.
- R9: A counter that passes its maximum value wraps modulo 2^32 and sets its overflow flag. The flag holds its interrupt high while further cycles pass.
- R10: Writing 1 to bit 0 of the overflow register clears the flag, and writing 0 has no effect. A wrap in the same cycle as a clear leaves the flag set.
- R11: Register address is {counter index, field}, with field in bits [1:0]: 0 event select (bits 7:0), 1 control, 2 counter value (writable), 3 overflow flag (bit 0). Reads return the addressed field zero-extended, combinationally.
- R12: A software write to a counter value in a cycle that also has a matching event loads the written value with no increment.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| dbg_en_i | input | 1 | Invasive debug enable |
| sec_dbg_en_i | input | 1 | Secure invasive debug enable |
| ni_dbg_en_i | input | 1 | Non-invasive debug enable |
| ev_pulse_i | input | NUM_PORTS*6 | Event pulses, bit p*6+k = class k on port p |
| ev_secure_i | input | NUM_PORTS | Per-port secure flag for this cycle's pulses |
| reg_wr_i | input | 1 | Register write strobe |
| reg_addr_i | input | clog2(NUM_CNT)+2 | Register address {counter, field} |
| reg_wdata_i | input | CNT_W | Write data |
| reg_rdata_o | output | CNT_W | Read data for reg_addr_i |
| ovf_irq_o | output | NUM_CNT | Per-counter overflow interrupt |

## Verification
The assertions check on every cycle that interrupts are low after reset, that a counter holds while invasive debug is off or while it selects an unsupported code, that no step exceeds the port count, that an interrupt rises only on a wrap, and that it stays up until a clear is written. The code-to-class map, the secure and non-secure gating, the exact multi-port sums, the enable bit, and the priority of software writes over increments and of set over clear can only be shown by the bench. It sweeps every code from 0 to 15 against every class and every combination of enables and secure flags.

// File: rtl/cohi_pmu_pkg.sv
package cohi_pmu_pkg;

    localparam int NUM_CLASS = 6;
    localparam int EVT_W     = 8;
    localparam int CLS_IDX_W = 3;

    typedef enum logic [1:0] {
        FLD_SEL   = 2'd0,
        FLD_CTRL  = 2'd1,
        FLD_COUNT = 2'd2,
        FLD_OVF   = 2'd3
    } reg_field_e;

    typedef struct packed {
        logic                 hit;
        logic [CLS_IDX_W-1:0] idx;
    } class_match_t;

    typedef struct packed {
        logic             en;
        logic [EVT_W-1:0] sel;
    } cnt_cfg_t;

    // Sparse select-code map onto the class inputs
    function automatic class_match_t match_code(input logic [EVT_W-1:0] code);
        class_match_t m;
        m.hit = 1'b1;
        m.idx = '0;
        case (code)
            8'd3:    m.idx = 3'd0;
            8'd4:    m.idx = 3'd1;
            8'd5:    m.idx = 3'd2;
            8'd6:    m.idx = 3'd3;
            8'd7:    m.idx = 3'd4;
            8'd9:    m.idx = 3'd5;
            default: m.hit = 1'b0;
        endcase
        return m;
    endfunction

endpackage

// File: rtl/cohi_pmu_tally.sv
module cohi_pmu_tally
    import cohi_pmu_pkg::*;
#(
    parameter int NUM_PORTS = 7,
    localparam int TALLY_W  = $clog2(NUM_PORTS + 1)
) (
    input  logic                                 dbg_en_i,
    input  logic                                 sec_dbg_en_i,
    input  logic                                 ni_dbg_en_i,
    input  logic [NUM_PORTS*NUM_CLASS-1:0]       ev_pulse_i,
    input  logic [NUM_PORTS-1:0]                 ev_secure_i,
    output logic [NUM_CLASS-1:0][TALLY_W-1:0]    tally_o
);

    logic [NUM_PORTS-1:0] port_ok;

    // A port's pulses count only under the enable that matches its security
    always_comb begin
        for (int p = 0; p < NUM_PORTS; p++) begin
            port_ok[p] = dbg_en_i && (ev_secure_i[p] ? sec_dbg_en_i : ni_dbg_en_i);
        end
    end

    always_comb begin
        for (int k = 0; k < NUM_CLASS; k++) begin
            tally_o[k] = '0;
            for (int p = 0; p < NUM_PORTS; p++) begin
                if (port_ok[p] && ev_pulse_i[p*NUM_CLASS + k]) begin
                    tally_o[k] = tally_o[k] + TALLY_W'(1);
                end
            end
        end
    end

endmodule

// File: rtl/cohi_pmu_counter.sv
module cohi_pmu_counter
    import cohi_pmu_pkg::*;
#(
    parameter int CNT_W   = 32,
    parameter int TALLY_W = 3
) (
    input  logic                              clk,
    input  logic                              rst,
    input  logic [NUM_CLASS-1:0][TALLY_W-1:0] tally_i,
    input  logic                              wr_sel_i,
    input  logic                              wr_ctrl_i,
    input  logic                              wr_cnt_i,
    input  logic                              wr_ovf_i,
    input  logic [CNT_W-1:0]                  wdata_i,
    output cnt_cfg_t                          cfg_o,
    output logic [CNT_W-1:0]                  cnt_o,
    output logic                              ovf_o
);

    cnt_cfg_t         cfg_q;
    logic [CNT_W-1:0] cnt_q;
    logic             ovf_q;
    class_match_t     m;
    logic [TALLY_W-1:0] inc;
    logic [CNT_W:0]   sum;

    always_comb begin
        m   = match_code(cfg_q.sel);
        inc = (cfg_q.en && m.hit) ? tally_i[m.idx] : '0;
        sum = {1'b0, cnt_q} + (CNT_W+1)'(inc);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            cfg_q <= '0;
            cnt_q <= '0;
            ovf_q <= 1'b0;
        end else begin
            if (wr_sel_i)  cfg_q.sel <= wdata_i[EVT_W-1:0];
            if (wr_ctrl_i) cfg_q.en  <= wdata_i[0];
            // software load beats the increment
            if (wr_cnt_i) cnt_q <= wdata_i;
            else          cnt_q <= sum[CNT_W-1:0];
            // a wrap beats a clear in the same cycle
            if (!wr_cnt_i && sum[CNT_W])     ovf_q <= 1'b1;
            else if (wr_ovf_i && wdata_i[0]) ovf_q <= 1'b0;
        end
    end

    assign cfg_o = cfg_q;
    assign cnt_o = cnt_q;
    assign ovf_o = ovf_q;

endmodule

// File: rtl/cohi_perfmon.sv
module cohi_perfmon
    import cohi_pmu_pkg::*;
#(
    parameter int NUM_PORTS = 7,
    parameter int NUM_CNT   = 8,
    parameter int CNT_W     = 32,
    localparam int CIDX_W   = $clog2(NUM_CNT),
    localparam int ADDR_W   = CIDX_W + 2
) (
    input  logic                           clk,
    input  logic                           rst,
    input  logic                           dbg_en_i,
    input  logic                           sec_dbg_en_i,
    input  logic                           ni_dbg_en_i,
    input  logic [NUM_PORTS*NUM_CLASS-1:0] ev_pulse_i,
    input  logic [NUM_PORTS-1:0]           ev_secure_i,
    input  logic                           reg_wr_i,
    input  logic [ADDR_W-1:0]              reg_addr_i,
    input  logic [CNT_W-1:0]               reg_wdata_i,
    output logic [CNT_W-1:0]               reg_rdata_o,
    output logic [NUM_CNT-1:0]             ovf_irq_o
);

    localparam int TALLY_W = $clog2(NUM_PORTS + 1);

    logic [NUM_CLASS-1:0][TALLY_W-1:0] tally;
    logic [CIDX_W-1:0]                 cidx;
    reg_field_e                        fld;
    cnt_cfg_t [NUM_CNT-1:0]            cfg_arr;
    logic [NUM_CNT-1:0][CNT_W-1:0]     cnt_flat;
    logic [NUM_CNT-1:0][EVT_W-1:0]     sel_flat;

    assign cidx = reg_addr_i[ADDR_W-1:2];
    assign fld  = reg_field_e'(reg_addr_i[1:0]);

    cohi_pmu_tally #(.NUM_PORTS(NUM_PORTS)) u_tally (
        .dbg_en_i     (dbg_en_i),
        .sec_dbg_en_i (sec_dbg_en_i),
        .ni_dbg_en_i  (ni_dbg_en_i),
        .ev_pulse_i   (ev_pulse_i),
        .ev_secure_i  (ev_secure_i),
        .tally_o      (tally)
    );

    for (genvar i = 0; i < NUM_CNT; i++) begin : g_cnt
        logic hit;
        assign hit = reg_wr_i && (cidx == CIDX_W'(i));

        cohi_pmu_counter #(.CNT_W(CNT_W), .TALLY_W(TALLY_W)) u_counter (
            .clk       (clk),
            .rst       (rst),
            .tally_i   (tally),
            .wr_sel_i  (hit && fld == FLD_SEL),
            .wr_ctrl_i (hit && fld == FLD_CTRL),
            .wr_cnt_i  (hit && fld == FLD_COUNT),
            .wr_ovf_i  (hit && fld == FLD_OVF),
            .wdata_i   (reg_wdata_i),
            .cfg_o     (cfg_arr[i]),
            .cnt_o     (cnt_flat[i]),
            .ovf_o     (ovf_irq_o[i])
        );

        assign sel_flat[i] = cfg_arr[i].sel;
    end

    always_comb begin
        case (fld)
            FLD_SEL:   reg_rdata_o = CNT_W'(cfg_arr[cidx].sel);
            FLD_CTRL:  reg_rdata_o = CNT_W'(cfg_arr[cidx].en);
            FLD_COUNT: reg_rdata_o = cnt_flat[cidx];
            default:   reg_rdata_o = CNT_W'(ovf_irq_o[cidx]);
        endcase
    end

endmodule

// File: rtl/cohi_perfmon_chk.sv
module cohi_perfmon_chk
    import cohi_pmu_pkg::*;
#(
    parameter int NUM_PORTS = 7,
    parameter int NUM_CNT   = 8,
    parameter int CNT_W     = 32,
    localparam int CIDX_W   = $clog2(NUM_CNT),
    localparam int ADDR_W   = CIDX_W + 2
) (
    input logic                          clk,
    input logic                          rst,
    input logic                          dbg_en_i,
    input logic                          reg_wr_i,
    input logic [ADDR_W-1:0]             reg_addr_i,
    input logic [CNT_W-1:0]              reg_wdata_i,
    input logic [NUM_CNT-1:0]            ovf_irq_o,
    input logic [NUM_CNT-1:0][CNT_W-1:0] cnt_flat,
    input logic [NUM_CNT-1:0][EVT_W-1:0] sel_flat
);

    AST_RESET_IRQ_LOW: assert property (@(posedge clk) rst |=> (ovf_irq_o == '0)); // R1

    for (genvar i = 0; i < NUM_CNT; i++) begin : g_chk
        logic wr_cnt, clr_ovf;
        assign wr_cnt  = reg_wr_i && reg_addr_i == {CIDX_W'(i), 2'd2};
        assign clr_ovf = reg_wr_i && reg_addr_i == {CIDX_W'(i), 2'd3} && reg_wdata_i[0];

        AST_DBG_OFF_HOLD: assert property (@(posedge clk) disable iff (rst)
            (!dbg_en_i && !wr_cnt) |=> $stable(cnt_flat[i])); // R4

        AST_UNSUP_HOLD: assert property (@(posedge clk) disable iff (rst)
            (!match_code(sel_flat[i]).hit && !wr_cnt) |=> $stable(cnt_flat[i])); // R3

        AST_STEP_BOUND: assert property (@(posedge clk) disable iff (rst)
            !wr_cnt |=> ((cnt_flat[i] - $past(cnt_flat[i])) <= CNT_W'(NUM_PORTS))); // R7

        AST_IRQ_ON_WRAP: assert property (@(posedge clk) disable iff (rst)
            $rose(ovf_irq_o[i]) |-> (cnt_flat[i] < $past(cnt_flat[i]))); // R9

        AST_IRQ_STICKY: assert property (@(posedge clk) disable iff (rst)
            (ovf_irq_o[i] && !clr_ovf) |=> ovf_irq_o[i]); // R10
    end

endmodule

bind cohi_perfmon cohi_perfmon_chk #(
    .NUM_PORTS (NUM_PORTS),
    .NUM_CNT   (NUM_CNT),
    .CNT_W     (CNT_W)
) u_chk (
    .clk         (clk),
    .rst         (rst),
    .dbg_en_i    (dbg_en_i),
    .reg_wr_i    (reg_wr_i),
    .reg_addr_i  (reg_addr_i),
    .reg_wdata_i (reg_wdata_i),
    .ovf_irq_o   (ovf_irq_o),
    .cnt_flat    (cnt_flat),
    .sel_flat    (sel_flat)
);

// File: tb/cohi_perfmon_bench.sv
module cohi_perfmon_bench;

    localparam int NP = 7;
    localparam int NK = 6;
    localparam int NCNT = 8;
    localparam int AW = 5;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic dbg_en = 1'b1, sec_en = 1'b1, ni_en = 1'b1;
    logic [NP*NK-1:0] ev = '0;
    logic [NP-1:0] sec = '0;
    logic reg_wr = 1'b0;
    logic [AW-1:0] reg_addr = '0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic [NCNT-1:0] irq;

    int n_chk = 0;
    int n_bad = 0;

    always #2.5 clk = ~clk;

    cohi_perfmon u_cohi_perfmon (
        .clk(clk), .rst(rst), .dbg_en_i(dbg_en), .sec_dbg_en_i(sec_en),
        .ni_dbg_en_i(ni_en), .ev_pulse_i(ev), .ev_secure_i(sec),
        .reg_wr_i(reg_wr), .reg_addr_i(reg_addr), .reg_wdata_i(reg_wdata),
        .reg_rdata_o(reg_rdata), .ovf_irq_o(irq)
    );

    function automatic int code_of(input int k);
        case (k)
            0: return 3;
            1: return 4;
            2: return 5;
            3: return 6;
            4: return 7;
            default: return 9;
        endcase
    endfunction

    function automatic logic [AW-1:0] ra(input int c, input int f);
        return AW'((c << 2) | f);
    endfunction

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
        end
    endtask

    task automatic wr(input int c, input int f, input logic [31:0] d);
        @(negedge clk);
        reg_wr = 1'b1; reg_addr = ra(c, f); reg_wdata = d;
        @(negedge clk);
        reg_wr = 1'b0;
    endtask

    task automatic rd(input int c, input int f, output logic [31:0] d);
        @(negedge clk);
        reg_addr = ra(c, f);
        #1 d = reg_rdata;
    endtask

    task automatic pulse(input logic [NP*NK-1:0] e, input logic [NP-1:0] s);
        @(negedge clk);
        ev = e; sec = s;
        @(negedge clk);
        ev = '0; sec = '0;
    endtask

    function automatic logic [NP*NK-1:0] one_ev(input int p, input int k);
        logic [NP*NK-1:0] v = '0;
        v[p*NK + k] = 1'b1;
        return v;
    endfunction

    initial begin
        repeat (100000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog: actual hung expected done");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        logic [31:0] d;
        repeat (3) @(negedge clk);
        rst = 1'b0;

        // R1 reset state
        for (int c = 0; c < NCNT; c++) begin
            rd(c, 2, d); check("R1 count", d, 0);
            rd(c, 0, d); check("R1 select", d, 0);
            rd(c, 1, d); check("R1 enable", d, 0);
        end
        check("R1 irq", 32'(irq), 0);

        // R2/R3 code x class sweep on counter 0
        wr(0, 1, 1);
        for (int code = 0; code < 16; code++) begin
            wr(0, 0, 32'(code));
            rd(0, 0, d); check("R11 select readback", d, 32'(code));
            for (int k = 0; k < NK; k++) begin
                wr(0, 2, 0);
                pulse(one_ev(k % NP, k), '0);
                rd(0, 2, d);
                check((code == code_of(k)) ? "R2 class map" : "R3 no count",
                      d, (code == code_of(k)) ? 1 : 0);
            end
        end

        // R4/R5/R6 enable combinations x secure flag
        wr(0, 0, 3);
        for (int g = 0; g < 8; g++) begin
            for (int s = 0; s < 2; s++) begin
                dbg_en = g[0]; sec_en = g[1]; ni_en = g[2];
                wr(0, 2, 0);
                pulse(one_ev(2, 0), s[0] ? 7'b0000100 : 7'b0);
                rd(0, 2, d);
                check(!g[0] ? "R4 dbg gate" : (s[0] ? "R5 secure gate" : "R6 nonsecure gate"),
                      d, (g[0] && (s[0] ? g[1] : g[2])) ? 1 : 0);
            end
        end
        dbg_en = 1; sec_en = 1; ni_en = 1;

        // R7 multi-port sums
        wr(0, 0, 4);
        for (int n = 0; n <= NP; n++) begin
            logic [NP*NK-1:0] v = '0;
            for (int p = 0; p < n; p++) v[p*NK + 1] = 1'b1;
            wr(0, 2, 0);
            pulse(v, '0);
            rd(0, 2, d); check("R7 port sum", d, 32'(n));
        end
        // R7 mixed security with secure enable off: only non-secure ports count
        sec_en = 0;
        wr(0, 2, 0);
        pulse({NP{6'b000010}}, 7'b1010101);
        rd(0, 2, d); check("R7 mixed sum", d, 3);
        sec_en = 1;

        // R8 enable bit
        wr(0, 2, 5); wr(0, 1, 0);
        pulse(one_ev(0, 1), '0);
        rd(0, 2, d); check("R8 disabled", d, 5);
        rd(0, 1, d); check("R8 ctrl readback", d, 0);
        wr(0, 1, 1);
        pulse(one_ev(0, 1), '0);
        rd(0, 2, d); check("R8 enabled", d, 6);

        // R11 independent counters
        for (int c = 0; c < NCNT; c++) begin
            wr(c, 0, (c < 6) ? 32'(code_of(c)) : ((c == 6) ? 9 : 8));
            wr(c, 1, 1);
            wr(c, 2, 0);
        end
        pulse(one_ev(0, 5), '0);
        for (int c = 0; c < NCNT; c++) begin
            rd(c, 2, d);
            check((c == 7) ? "R3 code 8 idle" : "R11 per-counter", d, (c == 5 || c == 6) ? 1 : 0);
        end

        // R9 wrap and sticky irq
        wr(0, 0, 3);
        wr(0, 2, 32'hFFFF_FFFE);
        pulse(one_ev(0, 0) | one_ev(1, 0) | one_ev(2, 0), '0);
        rd(0, 2, d); check("R9 wrap value", d, 1);
        check("R9 irq set", 32'(irq), 1);
        repeat (4) @(negedge clk);
        check("R9 irq held", 32'(irq), 1);
        rd(0, 3, d); check("R11 ovf readback", d, 1);

        // R10 clear semantics
        wr(0, 3, 0);
        check("R10 write0 no effect", 32'(irq), 1);
        wr(0, 3, 1);
        check("R10 write1 clears", 32'(irq), 0);
        wr(0, 2, 32'hFFFF_FFFF);
        @(negedge clk);
        ev = one_ev(3, 0); reg_wr = 1; reg_addr = ra(0, 3); reg_wdata = 1;
        @(negedge clk);
        ev = '0; reg_wr = 0;
        check("R10 set beats clear", 32'(irq), 1);
        rd(0, 2, d); check("R9 wrap to zero", d, 0);
        wr(0, 3, 1);

        // R12 load beats increment
        @(negedge clk);
        ev = one_ev(4, 0); reg_wr = 1; reg_addr = ra(0, 2); reg_wdata = 100;
        @(negedge clk);
        ev = '0; reg_wr = 0;
        rd(0, 2, d); check("R12 load priority", d, 100);
        check("R12 no irq", 32'(irq), 0);

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

endmodule